// File: doc/BRIEF.md
# Multi-Event Speaker Alarm Pulse Generator

This block drives the speaker of an eight-contestant quiz buzzer. Five event lines feed it. The first is the host's round-start control, which toggles. Then come two flags for the buzz phase: a contestant has won the buzz, or the buzz window has expired with no buzz. Last come two flags for the answer phase: the answerer signals completion, or the answer time has run out. Each event produces one active-low speaker pulse of fixed length.

Every input is brought into the clock domain through a two-flop synchroniser and then edge-detected. The host line fires on either edge. The other four lines fire only on a rising edge. All detected events are merged into a single load of a one-shot timer. The timer length is computed from the clock rate and the pulse length in milliseconds. By default this gives 100 ms at 32 MHz, which is 3,200,000 cycles.

An event that arrives while a pulse is active restarts the timer. The speaker therefore stays on until one full pulse length after the latest event.

Top module: `alarm_pulse_gen`

## Requirements
- R1: With no input events, `spk_n_o` stays 1 (silent) after reset.
- R2: A rising edge on `buzz_won_i` or `buzz_expired_i` produces a pulse. A falling edge on either produces none.
- R3: A rising edge on `ans_done_i` or `ans_timeout_i` produces a pulse. A falling edge on either produces none.
- R4: Both a rising and a falling edge on `host_start_i` produce a pulse.
- R5: An isolated event holds `spk_n_o` at 0 for exactly PULSE_CYC = CLK_HZ/1000*PULSE_MS consecutive cycles. This is 3,200,000 cycles by default.
- R6: Suppose an input changes before rising edge E0. Then `spk_n_o` reads 0 after rising edge E0+2. That is two synchroniser stages plus one timer register.
- R7: An event that arrives during an active pulse restarts the timer. The low period then ends PULSE_CYC cycles after that event takes effect.
- R8: Events on several inputs that take effect in the same cycle produce one pulse of exactly PULSE_CYC cycles.
- R9: The synchronous active-high `rst` drives `spk_n_o` to 1 on the next edge, including during an active pulse. Input levels that are held steady through reset produce no pulse after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_start_i | input | 1 | Host round-start toggle, asynchronous level |
| buzz_won_i | input | 1 | A contestant has won the buzz |
| buzz_expired_i | input | 1 | The buzz window expired with no buzz |
| ans_done_i | input | 1 | The answerer signals completion |
| ans_timeout_i | input | 1 | The answer time has run out |
| spk_n_o | output | 1 | Speaker drive, 0 = sound, 1 = silent |

## Verification
Two functions can fall in the same cycle. One is the timer load from a fresh event. The other is the expiry countdown of a pulse that is already running. A second case is two sources firing together.

The bench provokes these cases directly. It re-triggers a few cycles before the end of a pulse and exactly on its last low cycle. It also toggles several inputs in the same drive cycle.

Each low run is compared against a shift-register model built from input edges. The model predicts the output as low exactly when some event lies between 3 and PULSE_CYC+2 samples back. Run lengths are also checked: PULSE_CYC for a single or merged event, and gap plus PULSE_CYC for a retrigger.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    // Edge sensitivity chosen per event source
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_BOTH = 1'b1
    } edge_mode_e;

    // Source slot indices inside the merged event vector
    localparam int unsigned SRC_HOST    = 0;
    localparam int unsigned SRC_WON     = 1;
    localparam int unsigned SRC_EXPIRED = 2;
    localparam int unsigned SRC_DONE    = 3;
    localparam int unsigned SRC_TIMEOUT = 4;
    localparam int unsigned NUM_SRC     = 5;

    function automatic edge_mode_e mode_of(input int unsigned idx);
        return (idx == SRC_HOST) ? EDGE_BOTH : EDGE_RISE;
    endfunction

endpackage

// File: rtl/alarm_sync_edge.sv
module alarm_sync_edge
    import alarm_pkg::*;
#(
    parameter edge_mode_e MODE        = EDGE_RISE,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic event_o
);

    localparam int unsigned TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   hist;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (SYNC_STAGES > 1) begin
            st_d.chain = {st_q.chain[SYNC_STAGES-2:0], level_i};
        end else begin
            st_d.chain[0] = level_i;
        end
        // History follows the settled level; in reset this primes it
        st_d.hist = st_q.chain[TOP];
        if (rst) begin
            st_d.hist = st_q.chain[TOP];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    generate
        if (MODE == EDGE_BOTH) begin : g_both
            assign event_o = !rst && (st_q.chain[TOP] != st_q.hist);
        end else begin : g_rise
            assign event_o = !rst && st_q.chain[TOP] && !st_q.hist;
        end
    endgenerate

endmodule

// File: rtl/alarm_event_merge.sv
module alarm_event_merge #(
    parameter int unsigned N = 5
) (
    input  logic [N-1:0] ev_i,
    output logic         any_o
);

    always_comb begin
        any_o = 1'b0;
        for (int unsigned i = 0; i < N; i++) begin
            any_o = any_o | ev_i[i];
        end
    end

endmodule

// File: rtl/alarm_oneshot.sv
module alarm_oneshot #(
    parameter int unsigned PULSE_CYC = 3_200_000
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic spk_n_o
);

    localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } shot_st_t;

    shot_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt = '0;
        end else if (trig_i) begin
            st_d.cnt = LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign spk_n_o = (st_q.cnt == '0);

endmodule

// File: rtl/alarm_pulse_gen.sv
module alarm_pulse_gen
    import alarm_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 32_000_000,
    parameter int unsigned PULSE_MS    = 100,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic host_start_i,
    input  logic buzz_won_i,
    input  logic buzz_expired_i,
    input  logic ans_done_i,
    input  logic ans_timeout_i,
    output logic spk_n_o
);

    localparam int unsigned PULSE_CYC = CLK_HZ / 1000 * PULSE_MS;

    logic [NUM_SRC-1:0] src_lvl;
    logic [NUM_SRC-1:0] ev_vec;
    logic               ev_any;

    always_comb begin
        src_lvl              = '0;
        src_lvl[SRC_HOST]    = host_start_i;
        src_lvl[SRC_WON]     = buzz_won_i;
        src_lvl[SRC_EXPIRED] = buzz_expired_i;
        src_lvl[SRC_DONE]    = ans_done_i;
        src_lvl[SRC_TIMEOUT] = ans_timeout_i;
    end

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            alarm_sync_edge #(
                .MODE        (mode_of(i)),
                .SYNC_STAGES (SYNC_STAGES)
            ) u_edge (
                .clk     (clk),
                .rst     (rst),
                .level_i (src_lvl[i]),
                .event_o (ev_vec[i])
            );
        end
    endgenerate

    alarm_event_merge #(.N(NUM_SRC)) u_merge (
        .ev_i  (ev_vec),
        .any_o (ev_any)
    );

    alarm_oneshot #(.PULSE_CYC(PULSE_CYC)) u_shot (
        .clk     (clk),
        .rst     (rst),
        .trig_i  (ev_any),
        .spk_n_o (spk_n_o)
    );

endmodule

// File: rtl/alarm_pulse_gen_chk.sv
module alarm_pulse_gen_chk #(
    parameter int unsigned PULSE_CYC = 3_200_000
) (
    input logic clk,
    input logic rst,
    input logic ev_any,
    input logic spk_n
);

    localparam int unsigned AW = $clog2(PULSE_CYC + 2) + 1;
    localparam logic [AW-1:0] LIM = AW'(PULSE_CYC);

    // Cycles since the latest merged event, saturating past the window
    logic [AW-1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (ev_any) begin
            age_q <= AW'(1);
        end else if (age_q != '0 && age_q <= LIM) begin
            age_q <= age_q + 1'b1;
        end
    end

    // R6: a merged event lowers the speaker on the next edge
    a_r6_event_lowers: assert property (@(posedge clk) disable iff (rst)
        ev_any |=> !spk_n);

    // R5, R7: low for the whole window after the latest event
    a_r5_low_window: assert property (@(posedge clk) disable iff (rst)
        (age_q != '0 && age_q <= LIM) |-> !spk_n);

    // R1, R5: silent outside the window
    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        (age_q == '0 || age_q > LIM) |-> spk_n);

    // R9: reset silences the speaker on the next edge
    a_r9_reset_silent: assert property (@(posedge clk)
        rst |=> spk_n);

endmodule

bind alarm_pulse_gen alarm_pulse_gen_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ev_any (ev_any),
    .spk_n  (spk_n_o)
);

// File: tb/alarm_pulse_gen_tb.sv
`timescale 1ns/1ps
module alarm_pulse_gen_tb;

    localparam int unsigned CLK_HZ   = 25_000;
    localparam int unsigned PULSE_MS = 1;
    localparam int unsigned PULSE    = CLK_HZ / 1000 * PULSE_MS; // 25

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [4:0] in_v = 5'b0; // {timeout, done, expired, won, host}
    logic spk_n;

    int checks = 0;
    int errors = 0;
    logic [63:0] hist = '0;
    logic [4:0]  cur = 5'b0;
    logic        rst_drv = 1'b1;
    int          sidx = 0;
    int          run = 0;
    int          last_run = 0;
    int          fall_idx = -1;
    string       tag = "R1";

    always #2.5 clk = ~clk;

    alarm_pulse_gen #(.CLK_HZ(CLK_HZ), .PULSE_MS(PULSE_MS)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .host_start_i   (in_v[0]),
        .buzz_won_i     (in_v[1]),
        .buzz_expired_i (in_v[2]),
        .ans_done_i     (in_v[3]),
        .ans_timeout_i  (in_v[4]),
        .spk_n_o        (spk_n)
    );

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at sample %0d", t, act, exp, sidx);
        end
    endtask

    function automatic logic ev_of(input logic [4:0] o, input logic [4:0] n);
        logic e;
        e = (o[0] != n[0]);
        for (int i = 1; i < 5; i++) e = e | (n[i] & ~o[i]);
        return e;
    endfunction

    // One cycle: sample and compare at negedge, then drive next inputs
    task automatic cyc(input logic [4:0] nv, input logic nr);
        logic exp_n;
        @(negedge clk);
        sidx++;
        if (rst_drv) hist = '0;
        exp_n = ~|hist[PULSE+1:2];
        chk(spk_n === exp_n, tag, int'(spk_n), int'(exp_n));
        if (spk_n === 1'b0) begin
            if (run == 0) fall_idx = sidx;
            run++;
        end else if (run != 0) begin
            last_run = run;
            run = 0;
        end
        hist = {hist[62:0], (nr || rst_drv) ? 1'b0 : ev_of(cur, nv)};
        cur = nv;
        rst_drv = nr;
        in_v = nv;
        rst = nr;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(cur, 1'b0);
    endtask

    initial begin : watchdog
        #(5 * 150_000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int d0;
        void'($urandom(32'h5EED_1234));
        tag = "R9";
        for (int i = 0; i < 4; i++) cyc(5'b0, 1'b1);
        tag = "R1";
        cyc(5'b0, 1'b0);
        idle(60);

        // R2 rising buzz_won: latency and width
        tag = "R2";
        d0 = sidx + 1;
        cyc(5'b00010, 1'b0);
        idle(PULSE + 10);
        chk(fall_idx - d0 == 3, "R6 latency", fall_idx - d0, 3);
        chk(last_run == PULSE, "R5 width", last_run, PULSE);
        // falling edges give nothing (R2)
        cyc(5'b00000, 1'b0); idle(PULSE);
        chk(last_run == PULSE, "R2 no pulse on fall", last_run, PULSE);
        cyc(5'b00100, 1'b0); idle(PULSE + 5);
        cyc(5'b00000, 1'b0); idle(10);

        // R3 answer sources
        tag = "R3";
        cyc(5'b01000, 1'b0); idle(PULSE + 5);
        chk(last_run == PULSE, "R3 done width", last_run, PULSE);
        cyc(5'b00000, 1'b0); idle(10);
        cyc(5'b10000, 1'b0); idle(PULSE + 5);
        cyc(5'b00000, 1'b0); idle(10);

        // R4 host both edges
        tag = "R4";
        cyc(5'b00001, 1'b0); idle(PULSE + 5);
        chk(last_run == PULSE, "R4 rise width", last_run, PULSE);
        cyc(5'b00000, 1'b0); idle(PULSE + 5);
        chk(last_run == PULSE, "R4 fall width", last_run, PULSE);

        // R8 simultaneous sources
        tag = "R8";
        cyc(5'b11111, 1'b0); idle(PULSE + 5);
        chk(last_run == PULSE, "R8 merged width", last_run, PULSE);
        cyc(5'b00001, 1'b0); idle(5);

        // R7 retrigger mid-pulse and on last low cycle
        tag = "R7";
        cyc(5'b00011, 1'b0); idle(9);
        cyc(5'b00111, 1'b0); idle(PULSE + 5);
        chk(last_run == 10 + PULSE, "R7 retrigger width", last_run, 10 + PULSE);
        cyc(5'b00000, 1'b0); idle(PULSE + 5);
        cyc(5'b01000, 1'b0); idle(PULSE - 1);
        cyc(5'b11000, 1'b0); idle(PULSE + 5);
        chk(last_run == 2 * PULSE, "R7 last-cycle retrigger", last_run, 2 * PULSE);

        // R9 reset during pulse and with non-zero levels held
        tag = "R9";
        cyc(5'b11001, 1'b0); idle(6);
        cyc(cur, 1'b1);
        cyc(cur, 1'b1);
        chk(spk_n === 1'b1, "R9 reset silences", int'(spk_n), 1);
        cyc(cur, 1'b1);
        cyc(cur, 1'b0);
        idle(PULSE + 5);
        chk(spk_n === 1'b1, "R9 no pulse after reset", int'(spk_n), 1);

        // Random phase
        tag = "R7 random";
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] nv;
            nv = cur;
            if ($urandom_range(0, 19) == 0) nv[$urandom_range(0, 4)] ^= 1'b1;
            if ($urandom_range(0, 99) == 0) nv = nv ^ 5'($urandom());
            cyc(nv, 1'b0);
        end
        idle(PULSE + 5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule